// File: doc/BRIEF.md
# Flash Strobe Timing Controller

This controller drives the strobe line of a xenon flash so that the flash fires inside the vertical blanking interval of an image sensor. It watches four one-clock frame timing indicators: frame start, end of readout, end of pixel reset, and a level that is high during vertical blanking. When armed and enabled, it waits a programmed number of frames. It then waits for the chosen reference event, either the end of readout or the end of pixel reset. At the next blanking interval it raises the strobe for a programmed number of clocks.

The enable is captured at every frame start, and a read-only status output shows the captured value. The frame delay and the trigger selection are captured at the frame start that arms the controller. Each arming gives one pulse. To arm again, drive the enable low and then high. The strobe never extends past the end of blanking. A disable seen at a frame start cancels any pending or running pulse.

Top module: `flash_strobe_ctrl`

## Requirements
- R1: After reset, `strobe_o` and `strobe_enabled_o` are low.
- R2: `strobe_enabled_o` equals the value of `cfg_enable_i` sampled at the most recent `frame_start_i`. Changes to `cfg_enable_i` between frame starts do not show on it, and `strobe_o` is high only while it is high.
- R3: With `cfg_trig_sel_i` = 0 the reference event is `readout_done_i`, and with 1 it is `reset_done_i`. The other event never leads to a pulse.
- R4: Sample `vblank_i` at a clock edge, namely the first edge at which it is high after the reference event in the pulse frame. `strobe_o` goes high at that edge. While `vblank_i` stays high, it stays high for exactly `cfg_width_i` clocks.
- R5: If `vblank_i` is sampled low while the pulse runs, `strobe_o` goes low at that same edge and the pulse does not resume.
- R6: The controller is armed after reset and after each rising edge of `cfg_enable_i`. Arming is used up by a frame start with the enable high, and it yields at most one pulse.
- R7: A `frame_start_i` with `cfg_enable_i` low cancels any pending sequence and drops `strobe_o` at that same edge.
- R8: A `cfg_width_i` of zero gives no pulse but still uses up the arming.
- R9: The arming frame counts as frame 0, and the pulse falls in frame `cfg_delay_i` (0 to 3). Delay and trigger select are captured at the arming frame start, and changing them later has no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | One-clock frame start indicator |
| readout_done_i | input | 1 | One-clock end-of-readout indicator |
| reset_done_i | input | 1 | One-clock end-of-pixel-reset indicator |
| vblank_i | input | 1 | High during vertical blanking |
| cfg_enable_i | input | 1 | Flash enable; a rising edge re-arms |
| cfg_delay_i | input | DLY_W (2) | Frames to wait after the arming frame |
| cfg_trig_sel_i | input | 1 | Reference event: 0 readout done, 1 reset done |
| cfg_width_i | input | WIDTH_W (8) | Pulse width in clocks |
| strobe_o | output | 1 | Flash strobe |
| strobe_enabled_o | output | 1 | Read-only status: enable captured at last frame start |

## Verification
A frame counter left in the wrong state moves the whole pulse to another frame. This shows as a missing pulse or an extra one within one frame of the expected frame. A width counter that is off shows as a strobe one clock too long or too short, at the end of that same blanking interval. A stale arming flag shows as a second pulse in the frame after a correct one. A missed cancel leaves the strobe high past a disabling frame start for one clock or more.

// File: rtl/flash_strobe_pkg.sv
package flash_strobe_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE    = 2'd0,
        SCH_COUNT   = 2'd1,
        SCH_WAIT_VB = 2'd2
    } sched_state_e;

    localparam int unsigned DEF_DLY_W   = 2;
    localparam int unsigned DEF_WIDTH_W = 8;

endpackage

// File: rtl/flash_frame_sched.sv
module flash_frame_sched
    import flash_strobe_pkg::*;
#(
    parameter int unsigned DLY_W = DEF_DLY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             readout_done_i,
    input  logic             reset_done_i,
    input  logic             vblank_i,
    input  logic             cfg_enable_i,
    input  logic [DLY_W-1:0] cfg_delay_i,
    input  logic             cfg_trig_sel_i,
    output logic             launch_o,
    output logic             kill_o,
    output logic             enabled_o
);

    typedef struct packed {
        sched_state_e     state;
        logic [DLY_W-1:0] cnt;
        logic             armed;
        logic             en;
        logic             en_prev;
        logic             sel;
    } sched_regs_t;

    localparam sched_regs_t REGS_RESET = '{
        state:   SCH_IDLE,
        cnt:     '0,
        armed:   1'b1,
        en:      1'b0,
        en_prev: 1'b0,
        sel:     1'b1
    };

    sched_regs_t sch_d, sch_q;
    logic        launch_d;
    logic        kill_d;
    logic        en_rise;
    logic        ref_evt;

    always_comb begin
        sch_d    = sch_q;
        launch_d = 1'b0;
        kill_d   = frame_start_i & ~cfg_enable_i;
        en_rise  = cfg_enable_i & ~sch_q.en_prev;
        ref_evt  = sch_q.sel ? reset_done_i : readout_done_i;

        sch_d.en_prev = cfg_enable_i;
        if (en_rise) begin
            sch_d.armed = 1'b1;
        end
        if (frame_start_i) begin
            sch_d.en = cfg_enable_i;
        end

        unique case (sch_q.state)
            SCH_IDLE: begin
                if (frame_start_i && cfg_enable_i && (sch_q.armed || en_rise)) begin
                    sch_d.state = SCH_COUNT;
                    sch_d.cnt   = cfg_delay_i;
                    sch_d.sel   = cfg_trig_sel_i;
                end
            end
            SCH_COUNT: begin
                if (frame_start_i && (sch_q.cnt != '0)) begin
                    sch_d.cnt = sch_q.cnt - 1'b1;
                end else if ((sch_q.cnt == '0) && ref_evt) begin
                    sch_d.state = SCH_WAIT_VB;
                end
            end
            SCH_WAIT_VB: begin
                if (vblank_i) begin
                    launch_d    = 1'b1;
                    sch_d.state = SCH_IDLE;
                    sch_d.armed = 1'b0;
                end
            end
            default: begin
                sch_d.state = SCH_IDLE;
            end
        endcase

        if (kill_d) begin
            sch_d.state = SCH_IDLE;
            launch_d    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q <= REGS_RESET;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign launch_o  = launch_d;
    assign kill_o    = kill_d;
    assign enabled_o = sch_q.en;

    // A sequence in flight always belongs to an enabled frame.
    assert_busy_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q.state != SCH_IDLE) |-> sch_q.en);

    // A launch consumes the arming.
    assert_single_shot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> (!sch_q.armed && (sch_q.state == SCH_IDLE)));

    // The latched frame delay only moves on frame starts.
    assert_delay_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((sch_q.state == SCH_COUNT) && !frame_start_i) |=> $stable(sch_q.cnt));

endmodule

// File: rtl/flash_pulse_gen.sv
module flash_pulse_gen #(
    parameter int unsigned WIDTH_W = flash_strobe_pkg::DEF_WIDTH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_i,
    input  logic               kill_i,
    input  logic               vblank_i,
    input  logic [WIDTH_W-1:0] width_i,
    output logic               strobe_o
);

    typedef struct packed {
        logic               active;
        logic [WIDTH_W-1:0] cnt;
    } pulse_regs_t;

    pulse_regs_t pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (pg_q.active) begin
            if (kill_i || !vblank_i || (pg_q.cnt == WIDTH_W'(1))) begin
                pg_d.active = 1'b0;
                pg_d.cnt    = '0;
            end else begin
                pg_d.cnt = pg_q.cnt - 1'b1;
            end
        end else if (launch_i && !kill_i && (width_i != '0)) begin
            pg_d.active = 1'b1;
            pg_d.cnt    = width_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign strobe_o = pg_q.active;

    assert_width_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q.active && (pg_q.cnt == WIDTH_W'(1))) |=> !pg_q.active);

    assert_vblank_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_q.active && !vblank_i) |=> !pg_q.active);

    assert_kill_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kill_i |=> !pg_q.active);

    assert_zero_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pg_q.active && launch_i && (width_i == '0)) |=> !pg_q.active);

endmodule

// File: rtl/flash_strobe_ctrl.sv
module flash_strobe_ctrl
    import flash_strobe_pkg::*;
#(
    parameter int unsigned DLY_W   = DEF_DLY_W,
    parameter int unsigned WIDTH_W = DEF_WIDTH_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start_i,
    input  logic               readout_done_i,
    input  logic               reset_done_i,
    input  logic               vblank_i,
    input  logic               cfg_enable_i,
    input  logic [DLY_W-1:0]   cfg_delay_i,
    input  logic               cfg_trig_sel_i,
    input  logic [WIDTH_W-1:0] cfg_width_i,
    output logic               strobe_o,
    output logic               strobe_enabled_o
);

    logic launch;
    logic kill;

    flash_frame_sched #(.DLY_W(DLY_W)) sched_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_start_i  (frame_start_i),
        .readout_done_i (readout_done_i),
        .reset_done_i   (reset_done_i),
        .vblank_i       (vblank_i),
        .cfg_enable_i   (cfg_enable_i),
        .cfg_delay_i    (cfg_delay_i),
        .cfg_trig_sel_i (cfg_trig_sel_i),
        .launch_o       (launch),
        .kill_o         (kill),
        .enabled_o      (strobe_enabled_o)
    );

    flash_pulse_gen #(.WIDTH_W(WIDTH_W)) pulse_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .kill_i   (kill),
        .vblank_i (vblank_i),
        .width_i  (cfg_width_i),
        .strobe_o (strobe_o)
    );

    assert_strobe_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> strobe_enabled_o);

    assert_rise_in_vblank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> $past(vblank_i));

endmodule

// File: tb/flash_strobe_ctrl_tb_top.sv
module flash_strobe_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start_i = 1'b0;
    logic       readout_done_i = 1'b0;
    logic       reset_done_i = 1'b0;
    logic       vblank_i = 1'b0;
    logic       cfg_enable_i = 1'b0;
    logic [1:0] cfg_delay_i = 2'd0;
    logic       cfg_trig_sel_i = 1'b1;
    logic [7:0] cfg_width_i = 8'd0;
    logic       strobe_o;
    logic       strobe_enabled_o;

    int n_chk  = 0;
    int n_fail = 0;

    int f_hi, f_first, f_out, f_rise, f_kill_val;
    logic prev_strobe;

    always #4 clk = ~clk;

    flash_strobe_ctrl dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .frame_start_i    (frame_start_i),
        .readout_done_i   (readout_done_i),
        .reset_done_i     (reset_done_i),
        .vblank_i         (vblank_i),
        .cfg_enable_i     (cfg_enable_i),
        .cfg_delay_i      (cfg_delay_i),
        .cfg_trig_sel_i   (cfg_trig_sel_i),
        .cfg_width_i      (cfg_width_i),
        .strobe_o         (strobe_o),
        .strobe_enabled_o (strobe_enabled_o)
    );

    typedef struct packed {
        logic       en;
        logic [1:0] dly;
        logic       sel;
        logic [7:0] width;
        logic [7:0] vb;
        logic [2:0] exp_frame;   // 7 = no pulse expected
        logic [7:0] exp_hi;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd0, 1'b0, 8'd4,  8'd10, 3'd0, 8'd4},
        '{1'b1, 2'd1, 1'b1, 8'd3,  8'd10, 3'd1, 8'd3},
        '{1'b1, 2'd3, 1'b0, 8'd6,  8'd10, 3'd3, 8'd6},
        '{1'b1, 2'd2, 1'b1, 8'd1,  8'd10, 3'd2, 8'd1},
        '{1'b1, 2'd0, 1'b1, 8'd20, 8'd5,  3'd0, 8'd5},
        '{1'b1, 2'd0, 1'b0, 8'd0,  8'd10, 3'd7, 8'd0},
        '{1'b0, 2'd0, 1'b0, 8'd4,  8'd10, 3'd7, 8'd0},
        '{1'b1, 2'd1, 1'b0, 8'd9,  8'd10, 3'd1, 8'd9}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic fs, input logic rd, input logic rs, input logic vb);
        @(negedge clk);
        frame_start_i  = fs;
        readout_done_i = rd;
        reset_done_i   = rs;
        vblank_i       = vb;
        @(posedge clk);
        #1;
        if (strobe_o && !prev_strobe) f_rise++;
        prev_strobe = strobe_o;
    endtask

    task automatic run_frame(input logic rd_en, input logic rs_en, input int vb_len, input int kill_at);
        f_hi = 0; f_first = -1; f_out = 0; f_rise = 0; f_kill_val = -1;
        prev_strobe = strobe_o;
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        if (strobe_o) f_out++;
        for (int a = 0; a < 12; a++) begin
            drive(1'b0, rd_en && (a == 9), rs_en && (a == 2), 1'b0);
            if (strobe_o) f_out++;
        end
        for (int v = 0; v < vb_len; v++) begin
            if (v == kill_at) begin
                cfg_enable_i = 1'b0;
                drive(1'b1, 1'b0, 1'b0, 1'b1);
                f_kill_val = int'(strobe_o);
            end else begin
                drive(1'b0, 1'b0, 1'b0, 1'b1);
            end
            if (strobe_o) begin
                f_hi++;
                if (f_first < 0) f_first = v;
            end
        end
        for (int t = 0; t < 2; t++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0);
            if (strobe_o) f_out++;
        end
    endtask

    task automatic disarm();
        cfg_enable_i = 1'b0;
        run_frame(1'b1, 1'b1, 10, -1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check(strobe_o == 1'b0, "R1 strobe after reset", int'(strobe_o), 0);
        check(strobe_enabled_o == 1'b0, "R1 status after reset", int'(strobe_enabled_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(strobe_o == 1'b0, "R1 strobe after release", int'(strobe_o), 0);

        // Table of vectors: R3 R4 R5 R6 R8 R9
        for (int i = 0; i < NVEC; i++) begin
            disarm();
            check(strobe_enabled_o == 1'b0, "R2 status after disarm", int'(strobe_enabled_o), 0);
            cfg_delay_i    = VECS[i].dly;
            cfg_trig_sel_i = VECS[i].sel;
            cfg_width_i    = VECS[i].width;
            cfg_enable_i   = VECS[i].en;
            for (int f = 0; f < 4; f++) begin
                int exp_hi;
                run_frame(1'b1, 1'b1, int'(VECS[i].vb), -1);
                exp_hi = (f == int'(VECS[i].exp_frame)) ? int'(VECS[i].exp_hi) : 0;
                check(f_hi == exp_hi, "R4 R9 R8 R6 strobe cycles in frame", f_hi, exp_hi);
                check(f_out == 0, "R5 strobe outside blanking", f_out, 0);
                check(f_rise == ((exp_hi != 0) ? 1 : 0), "R6 pulse count in frame", f_rise,
                      (exp_hi != 0) ? 1 : 0);
                if (exp_hi != 0) begin
                    check(f_first == 0, "R4 pulse start offset", f_first, 0);
                end
            end
            check(strobe_enabled_o == VECS[i].en, "R2 status follows enable",
                  int'(strobe_enabled_o), int'(VECS[i].en));
        end

        // R2: status only updates at frame start
        disarm();
        cfg_delay_i = 2'd0; cfg_trig_sel_i = 1'b0; cfg_width_i = 8'd4;
        cfg_enable_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check(strobe_enabled_o == 1'b0, "R2 status holds before frame start", int'(strobe_enabled_o), 0);
        run_frame(1'b1, 1'b1, 10, -1);
        check(strobe_enabled_o == 1'b1, "R2 status set at frame start", int'(strobe_enabled_o), 1);
        cfg_enable_i = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(strobe_enabled_o == 1'b1, "R2 status holds after enable drop", int'(strobe_enabled_o), 1);

        // R3: the non-selected event is ignored
        disarm();
        cfg_delay_i = 2'd0; cfg_trig_sel_i = 1'b0; cfg_width_i = 8'd4;
        cfg_enable_i = 1'b1;
        run_frame(1'b0, 1'b1, 10, -1);
        check(f_hi == 0, "R3 reset event ignored when readout selected", f_hi, 0);
        run_frame(1'b1, 1'b0, 10, -1);
        check(f_hi == 4, "R3 readout event fires pulse", f_hi, 4);

        // R9: delay and select captured at arming
        disarm();
        cfg_delay_i = 2'd2; cfg_trig_sel_i = 1'b1; cfg_width_i = 8'd4;
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 0, "R9 arming frame quiet", f_hi, 0);
        cfg_delay_i = 2'd0; cfg_trig_sel_i = 1'b0;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 0, "R9 later delay change ignored", f_hi, 0);
        run_frame(1'b0, 1'b1, 10, -1);
        check(f_hi == 4, "R9 latched select and delay used", f_hi, 4);

        // R7: disable at a frame start during the pulse
        disarm();
        cfg_delay_i = 2'd0; cfg_trig_sel_i = 1'b0; cfg_width_i = 8'd8;
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 16, 3);
        check(f_kill_val == 0, "R7 strobe low at disabling frame start", f_kill_val, 0);
        check(f_hi == 3, "R7 truncated pulse length", f_hi, 3);
        check(strobe_enabled_o == 1'b0, "R7 status cleared", int'(strobe_enabled_o), 0);

        // R7: disable cancels a pending sequence
        disarm();
        cfg_delay_i = 2'd2; cfg_trig_sel_i = 1'b0; cfg_width_i = 8'd4;
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 10, -1);
        cfg_enable_i = 1'b0;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 0, "R7 disabled frame quiet", f_hi, 0);
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 0, "R7 cancelled pulse not issued", f_hi, 0);

        // R6: re-arm through an enable toggle between frame starts
        disarm();
        cfg_delay_i = 2'd0; cfg_trig_sel_i = 1'b1; cfg_width_i = 8'd2;
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 2, "R6 first pulse", f_hi, 2);
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 0, "R6 no pulse without re-arm", f_hi, 0);
        cfg_enable_i = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        cfg_enable_i = 1'b1;
        run_frame(1'b1, 1'b1, 10, -1);
        check(f_hi == 2, "R6 pulse after re-arm", f_hi, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule